// File: doc/BRIEF.md
# Cache Way LRU Tracker

This block holds the true least-recently-used ordering for one set of an N-way set-associative cache. The way count is a parameter and must be a power of two of at least two. Every way carries a rank from 0 (least recent) up to N-1 (most recent). The ranks always form a permutation of 0 to N-1, so the ordering is complete and never partial.

Each request has a valid strobe, a two-bit operation code and a binary way index. A read marks a way as just used. A write asks for a victim: the block returns the least recent way and promotes it to most recent, so that way is filled next. An invalidate demotes a way to least recent, so the next write picks it. The answer comes back one cycle later as a one-hot way vector with a valid flag. A controller drives the block with hits, fills and invalidations, and uses the returned vector directly as a way enable.

Top module: `lru_tracker`

## Requirements
- R1: During and after an asynchronous reset, res_valid is low and res_way is all zeros. The ordering then runs from way 0 (least recent) to way N-1 (most recent), so the first N writes return ways 0, 1, ..., N-1 in that order.
- R2: A request is taken only in a cycle where req_valid is high. When req_valid is low, req_op and req_way change neither the ordering nor the output.
- R3: Every accepted read, write or invalidate produces exactly one result cycle: res_valid is high on the clock edge that follows the request. In a cycle with no result, res_valid is low and res_way is zero. Requests may arrive back to back.
- R4: Read (req_op = 2'b00) makes way req_way the most recent, and res_way has only bit req_way set.
- R5: Write (req_op = 2'b01) returns the current least recent way one-hot and makes that way the most recent. req_way is ignored for a write.
- R6: Invalidate (req_op = 2'b10) makes way req_way the least recent, so the following write returns it. res_way has only bit req_way set.
- R7: req_op = 2'b11 is reserved. It does nothing: it produces no result and leaves the ordering unchanged.
- R8: req_way is a binary index of log2(N) bits. In res_way, bit i stands for way i, and when res_valid is high exactly one bit is set.
- R9: Exactly one way is least recent at all times. Any N consecutive writes with no other request between them return all N ways, each once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | Operation: 00 read, 01 write, 10 invalidate, 11 reserved |
| req_way | input | log2(N) | Way index for read and invalidate |
| res_valid | output | 1 | res_way holds a result this cycle |
| res_way | output | N | One-hot result way |

## Verification
The assertions check on every cycle that the output has a single set bit when valid, that idle and reserved cycles give no result and leave the ranks unchanged, that reads and invalidates echo the requested way, that writes return the way that held rank zero, and that exactly one way holds rank zero. Whether the whole ordering is right after long mixed sequences of promotions and demotions is something only the bench's scenarios can show. The bench compares every result against an independent list model, starting from the reset order, through idle gaps and reserved codes.

// File: rtl/lru_pkg.sv
package lru_pkg;
   typedef enum logic [1:0] {
      OP_READ  = 2'b00,
      OP_WRITE = 2'b01,
      OP_INVAL = 2'b10,
      OP_NONE  = 2'b11
   } lru_op_e;
endpackage

// File: rtl/lru_age_cell.sv
// Rank register for one way: 0 is least recent, N-1 most recent.
module lru_age_cell #(
   parameter int N         = 8,
   parameter int IW        = $clog2(N),
   parameter int RESET_AGE = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          upd_en,
   input  logic          to_mru,
   input  logic          is_target,
   input  logic [IW-1:0] target_age,
   output logic [IW-1:0] age
);
   localparam logic [IW-1:0] TOP_AGE  = IW'(N - 1);
   localparam logic [IW-1:0] INIT_AGE = IW'(RESET_AGE);

   logic [IW-1:0] age_d;

   always_comb begin
      age_d = age;
      if (upd_en) begin
         if (is_target) begin
            age_d = to_mru ? TOP_AGE : '0;
         end else if (to_mru && (age > target_age)) begin
            age_d = age - 1'b1;
         end else if (!to_mru && (age < target_age)) begin
            age_d = age + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) age <= INIT_AGE;
      else        age <= age_d;
   end

   // R2 / R7: without an update the rank does not move
   a_r7_cell_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_en |=> $stable(age));
endmodule

// File: rtl/lru_victim_find.sv
// Finds the way whose rank is zero.
module lru_victim_find #(
   parameter int N  = 8,
   parameter int IW = $clog2(N)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N-1:0][IW-1:0] ages,
   output logic [N-1:0]         victim_oh,
   output logic [IW-1:0]        victim_idx
);
   for (genvar i = 0; i < N; i++) begin : g_zero
      assign victim_oh[i] = (ages[i] == '0);
   end

   always_comb begin
      victim_idx = '0;
      for (int i = 0; i < N; i++) begin
         if (victim_oh[i]) victim_idx = victim_idx | IW'(i);
      end
   end

   // R9: the ranks stay a permutation, so exactly one way is least recent
   a_r9_single_lru: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(victim_oh) == 1);
endmodule

// File: rtl/lru_onehot_dec.sv
module lru_onehot_dec #(
   parameter int N  = 8,
   parameter int IW = $clog2(N)
) (
   input  logic [IW-1:0] idx,
   output logic [N-1:0]  oh
);
   for (genvar i = 0; i < N; i++) begin : g_dec
      assign oh[i] = (idx == IW'(i));
   end
endmodule

// File: rtl/lru_tracker.sv
module lru_tracker
   import lru_pkg::*;
#(
   parameter int N  = 8,
   parameter int IW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [1:0]    req_op,
   input  logic [IW-1:0] req_way,
   output logic          res_valid,
   output logic [N-1:0]  res_way
);
   initial begin : p_param_chk
      assert ((N >= 2) && ((N & (N - 1)) == 0))
         else $fatal(1, "lru_tracker: N must be a power of two, at least 2");
      assert (IW == $clog2(N))
         else $fatal(1, "lru_tracker: IW must equal log2(N)");
   end

   lru_op_e               op;
   logic                  accept;
   logic                  to_mru;
   logic [N-1:0][IW-1:0]  age_q;
   logic [N-1:0]          victim_oh;
   logic [IW-1:0]         victim_idx;
   logic [IW-1:0]         tgt_idx;
   logic [N-1:0]          tgt_oh;
   logic [IW-1:0]         tgt_age;

   assign op      = lru_op_e'(req_op);
   assign accept  = req_valid && (op != OP_NONE);
   assign to_mru  = (op != OP_INVAL);
   assign tgt_idx = (op == OP_WRITE) ? victim_idx : req_way;
   assign tgt_age = age_q[tgt_idx];

   lru_victim_find #(.N(N), .IW(IW)) u_victim (
      .clk        (clk),
      .rst_n      (rst_n),
      .ages       (age_q),
      .victim_oh  (victim_oh),
      .victim_idx (victim_idx)
   );

   lru_onehot_dec #(.N(N), .IW(IW)) u_dec (
      .idx (tgt_idx),
      .oh  (tgt_oh)
   );

   for (genvar i = 0; i < N; i++) begin : g_way
      lru_age_cell #(.N(N), .IW(IW), .RESET_AGE(i)) u_cell (
         .clk        (clk),
         .rst_n      (rst_n),
         .upd_en     (accept),
         .to_mru     (to_mru),
         .is_target  (tgt_oh[i]),
         .target_age (tgt_age),
         .age        (age_q[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_way   <= '0;
      end else begin
         res_valid <= accept;
         res_way   <= accept ? tgt_oh : '0;
      end
   end

   // R3: every accepted request yields a result on the next edge
   a_r3_result_next: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_op != 2'b11)) |=> res_valid);
   // R2 / R7: idle or reserved cycles yield nothing
   a_r7_no_result: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_valid || (req_op == 2'b11)) |=> (!res_valid && (res_way == '0)));
   // R8: one-hot when valid
   a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> ($countones(res_way) == 1));
   // R4: read echoes its way
   a_r4_read_echo: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_op == 2'b00)) |=> (res_way == (N'(1) << $past(req_way))));
   // R6: invalidate echoes its way
   a_r6_inval_echo: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_op == 2'b10)) |=> (res_way == (N'(1) << $past(req_way))));
   // R5: write returns the way that held rank zero
   a_r5_write_victim: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_op == 2'b01)) |=> (res_way == $past(victim_oh)));
   // R6: an invalidated way becomes the victim
   a_r6_inval_lru: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_op == 2'b10)) |=> (victim_oh == (N'(1) << $past(req_way))));
   // R2 / R7: ordering held when nothing is accepted
   a_r2_hold_order: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_valid || (req_op == 2'b11)) |=> $stable(age_q));
endmodule

// File: tb/lru_tracker_tb.sv
module lru_tracker_tb;
   localparam int N      = 4;
   localparam int IW     = 2;
   localparam int CLK_NS = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_op = 2'b00;
   logic [IW-1:0] req_way = '0;
   logic          res_valid;
   logic [N-1:0]  res_way;

   int checks = 0;
   int errors = 0;
   int order [N];          // order[0] least recent
   logic [15:0] lfsr = 16'hACE1;

   always #(CLK_NS/2) clk = ~clk;

   lru_tracker #(.N(N), .IW(IW)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_op    (req_op),
      .req_way   (req_way),
      .res_valid (res_valid),
      .res_way   (res_way)
   );

   task automatic check(input string req, input logic got_v, input logic [N-1:0] got_w,
                        input logic exp_v, input logic [N-1:0] exp_w);
      checks++;
      if (got_v !== exp_v || got_w !== exp_w) begin
         errors++;
         $display("FAIL %s: got valid=%0b way=%b, expected valid=%0b way=%b",
                  req, got_v, got_w, exp_v, exp_w);
      end
   endtask

   function automatic int find_pos(input int w);
      for (int p = 0; p < N; p++) if (order[p] == w) return p;
      return 0;
   endfunction

   function automatic void to_back(input int w);
      int p = find_pos(w);
      for (int k = p; k < N - 1; k++) order[k] = order[k+1];
      order[N-1] = w;
   endfunction

   function automatic void to_front(input int w);
      int p = find_pos(w);
      for (int k = p; k > 0; k--) order[k] = order[k-1];
      order[0] = w;
   endfunction

   // Called at a falling edge; returns at the next falling edge after checking.
   task automatic do_op(input logic v, input logic [1:0] op, input int w, input string req);
      logic          ev;
      logic [N-1:0]  ew;
      int            tgt;
      ev  = v && (op != 2'b11);
      tgt = (op == 2'b01) ? order[0] : w;
      ew  = ev ? (N'(1) << tgt) : '0;
      req_valid = v;
      req_op    = op;
      req_way   = IW'(w);
      @(negedge clk);
      check(req, res_valid, res_way, ev, ew);
      if (ev) begin
         if (op == 2'b10) to_front(tgt);
         else             to_back(tgt);
      end
      req_valid = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      for (int i = 0; i < N; i++) order[i] = i;
      repeat (3) @(negedge clk);
      check("R1 reset", res_valid, res_way, 1'b0, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", res_valid, res_way, 1'b0, '0);

      // R1 R5 R9: first N writes walk the reset order; req_way ignored
      for (int i = 0; i < N; i++) do_op(1'b1, 2'b01, N - 1 - i, "R1 R5 reset order write");

      // R3: idle cycle after a result has no result
      do_op(1'b0, 2'b00, 0, "R3 idle gap");

      // R2: junk on op/way while valid is low
      do_op(1'b0, 2'b10, 3, "R2 invalid strobe");
      do_op(1'b1, 2'b01, 0, "R2 order kept after ignored request");

      // R7: reserved code, then a write must match the unchanged order
      do_op(1'b1, 2'b11, 2, "R7 reserved op");
      do_op(1'b1, 2'b01, 1, "R7 order kept after reserved");

      // R4 R8: read each way, back to back
      for (int w = 0; w < N; w++) do_op(1'b1, 2'b00, w, "R4 R8 read echo");

      // R6: invalidate each way, next write returns it
      for (int w = 0; w < N; w++) begin
         do_op(1'b1, 2'b10, w, "R6 invalidate echo");
         do_op(1'b1, 2'b01, 0, "R6 write after invalidate");
      end

      // Sweep every op on every way from many states
      for (int i = 0; i < 1500; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         do_op(lfsr[4] | lfsr[5], lfsr[1:0], int'(lfsr[3:2]), "R3 R4 R5 R6 R7 sweep");
      end

      // R9: N writes in a row cover every way exactly once
      begin
         logic [N-1:0] seen = '0;
         for (int i = 0; i < N; i++) begin
            do_op(1'b1, 2'b01, 0, "R9 write run");
            seen = seen | res_way;
         end
         check("R9 all ways victimised", 1'b1, seen, 1'b1, {N{1'b1}});
      end

      // R1: asynchronous reset mid-run restores the reset order
      #(CLK_NS/4) rst_n = 1'b0;
      #1;
      check("R1 async reset", res_valid, res_way, 1'b0, '0);
      for (int i = 0; i < N; i++) order[i] = i;
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < N; i++) do_op(1'b1, 2'b01, 0, "R1 order after second reset");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule